// File: doc/BRIEF.md
# Inbound Memory Window Decoder

This block decides whether an address arriving from the expansion bus lands in one of three programmable inbound memory windows, and if so, which window claims it and what local memory address it maps to. Each window is set by one 32-bit register. The register holds a 1 MB granular base in its upper twelve bits and a 4-bit power-of-two size code just below that. All three windows are compared against the incoming address at the same time. When more than one window matches, a fixed priority picks the winner.

Software, or a boot sequencer, programs the windows through a single-cycle register-write port. The bus side offers a lookup address with a valid strobe. One clock later the block returns a registered response. The response is a hit flag, the 2-bit number of the winning window, and the translated local address. Every window maps onto local memory starting at a common local base, which is zero by default. The translated address is therefore the offset of the request inside its window. Bus timing and data movement belong to the surrounding logic.

Top module: `imw_decoder`

## Requirements
- R1: After reset, `rsp_valid` is low and every window holds the reserved size code 0xF. A lookup made right after reset therefore misses.
- R2: A write with `cfg_we` high loads window register 0, 1 or 2 when `cfg_addr` is 0x50, 0x54 or 0x58 respectively. Data bits 31..20 become the window base, and bits 19..16 become the size code. Data bits 15..0 have no effect, and a write to any other address has no effect.
- R3: A size code n from 0 to 11 gives a window of 2^(20+n) bytes, from 1 MB up to 2 GB. An address hits the window exactly when its bits 31..(20+n) equal the same bits of the base. Both ends of the window hit, and the bytes just outside it miss.
- R4: Base bits below the window size are ignored. For example, a 32 MB window written with base 0x235 covers 0x2200_0000 to 0x23FF_FFFF.
- R5: A window with a reserved size code (0xC to 0xF) never hits.
- R6: When several windows hit, the lowest-numbered one wins. `rsp_win` carries its index (0, 1 or 2).
- R7: On a hit, `rsp_local` equals the local base (0) plus the request address modulo the window size.
- R8: The response is registered. `rsp_valid` is high exactly in the cycle after a cycle with `lk_valid` high. On a miss, and whenever `rsp_valid` is low, `rsp_hit`, `rsp_win` and `rsp_local` are all zero.
- R9: A lookup in the same cycle as a register write is judged against the window contents from before the write. The new contents apply to lookups from the following cycle onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| lk_valid | input | 1 | Lookup request strobe |
| lk_addr | input | 32 | Incoming bus address to decode |
| rsp_valid | output | 1 | Response valid, one cycle after `lk_valid` |
| rsp_hit | output | 1 | Some window claims the address |
| rsp_win | output | 2 | Index of the winning window |
| rsp_local | output | 32 | Translated local address |

## Verification
A register write and a lookup can fall in the same clock edge, and so can the match results of several windows. The bench provokes the first case by driving a write and a lookup in one cycle to an address that only the new window contents would claim. It expects a miss from that lookup and a hit from an identical lookup one cycle later. Overlapping windows are judged by the reported index and offset. Disabling the winner with a reserved code must hand the address to the next window in line.

// File: rtl/imw_pkg.sv
`timescale 1ns/1ps
package imw_pkg;
    localparam int ADDR_W    = 32;
    localparam int NUM_WIN   = 3;
    localparam int GRAN_LOG2 = 20;
    localparam int CODE_W    = 4;
    localparam int MAX_CODE  = 11;
    localparam int CFG_AW    = 8;
    localparam int IDX_W     = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
    localparam logic [CFG_AW-1:0] FIRST_OFS = 8'h50;
    localparam logic [CODE_W-1:0] OFF_CODE  = 4'hF;

    typedef struct packed {
        logic [ADDR_W-1:GRAN_LOG2] base;
        logic [CODE_W-1:0]         code;
    } win_cfg_t;
endpackage

// File: rtl/imw_win_regs.sv
`timescale 1ns/1ps
module imw_win_regs
    import imw_pkg::*;
#(
    parameter int N_WIN = NUM_WIN
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [CFG_AW-1:0]       cfg_addr,
    input  logic [ADDR_W-1:0]       cfg_wdata,
    output win_cfg_t [N_WIN-1:0]    win_cfg
);
    localparam int FIELD_LO = GRAN_LOG2 - CODE_W;

    win_cfg_t wr_val;
    logic     unused_low;

    assign wr_val.base = cfg_wdata[ADDR_W-1:GRAN_LOG2];
    assign wr_val.code = cfg_wdata[GRAN_LOG2-1:FIELD_LO];
    assign unused_low  = ^cfg_wdata[FIELD_LO-1:0];

    for (genvar i = 0; i < N_WIN; i++) begin : g_reg
        localparam logic [CFG_AW-1:0] MY_OFS = FIRST_OFS + CFG_AW'(4 * i);
        logic sel;
        assign sel = cfg_we && (cfg_addr == MY_OFS);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                win_cfg[i].base <= '0;
                win_cfg[i].code <= OFF_CODE;
            end else if (sel) begin
                win_cfg[i] <= wr_val;
            end
        end
    end
endmodule

// File: rtl/imw_win_match.sv
`timescale 1ns/1ps
module imw_win_match
    import imw_pkg::*;
(
    input  win_cfg_t          cfg,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [ADDR_W-1:0] offset
);
    logic              code_ok;
    logic [ADDR_W-1:0] span_mask;
    logic [ADDR_W-1:0] base_full;

    assign code_ok   = (int'(cfg.code) <= MAX_CODE);
    assign base_full = {cfg.base, {GRAN_LOG2{1'b0}}};

    always_comb begin
        for (int b = 0; b < ADDR_W; b++) begin
            span_mask[b] = (b < GRAN_LOG2 + int'(cfg.code));
        end
    end

    assign hit    = code_ok && (((addr ^ base_full) & ~span_mask) == '0);
    assign offset = addr & span_mask;
endmodule

// File: rtl/imw_prio_pick.sv
`timescale 1ns/1ps
module imw_prio_pick
    import imw_pkg::*;
#(
    parameter int N_WIN = NUM_WIN
) (
    input  logic [N_WIN-1:0]             hits,
    input  logic [N_WIN-1:0][ADDR_W-1:0] offsets,
    output logic                         any_hit,
    output logic [IDX_W-1:0]             win_idx,
    output logic [ADDR_W-1:0]            win_ofs
);
    always_comb begin
        any_hit = 1'b0;
        win_idx = '0;
        win_ofs = '0;
        for (int i = N_WIN - 1; i >= 0; i--) begin
            if (hits[i]) begin
                any_hit = 1'b1;
                win_idx = IDX_W'(i);
                win_ofs = offsets[i];
            end
        end
    end
endmodule

// File: rtl/imw_decoder.sv
`timescale 1ns/1ps
module imw_decoder
    import imw_pkg::*;
#(
    parameter logic [ADDR_W-1:0] LOCAL_BASE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              lk_valid,
    input  logic [31:0]       lk_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [1:0]        rsp_win,
    output logic [31:0]       rsp_local
);
    win_cfg_t [NUM_WIN-1:0]         win_cfg;
    logic [NUM_WIN-1:0]             win_hit;
    logic [NUM_WIN-1:0][ADDR_W-1:0] win_ofs;
    logic                           any_hit;
    logic [IDX_W-1:0]               pick_idx;
    logic [ADDR_W-1:0]              pick_ofs;

    imw_win_regs #(.N_WIN(NUM_WIN)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .win_cfg   (win_cfg)
    );

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_match
        imw_win_match u_match (
            .cfg    (win_cfg[i]),
            .addr   (lk_addr),
            .hit    (win_hit[i]),
            .offset (win_ofs[i])
        );
    end

    imw_prio_pick #(.N_WIN(NUM_WIN)) u_pick (
        .hits    (win_hit),
        .offsets (win_ofs),
        .any_hit (any_hit),
        .win_idx (pick_idx),
        .win_ofs (pick_ofs)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_win   <= '0;
            rsp_local <= '0;
        end else begin
            rsp_valid <= lk_valid;
            if (lk_valid && any_hit) begin
                rsp_hit   <= 1'b1;
                rsp_win   <= pick_idx;
                rsp_local <= LOCAL_BASE + pick_ofs;
            end else begin
                rsp_hit   <= 1'b0;
                rsp_win   <= '0;
                rsp_local <= '0;
            end
        end
    end
endmodule

// File: rtl/imw_decoder_chk.sv
`timescale 1ns/1ps
module imw_decoder_chk #(
    parameter int          GRAN       = 20,
    parameter int          NWIN       = 3,
    parameter logic [31:0] LBASE      = '0
) (
    input logic        clk,
    input logic        rst_n,
    input logic        lk_valid,
    input logic [31:0] lk_addr,
    input logic        rsp_valid,
    input logic        rsp_hit,
    input logic [1:0]  rsp_win,
    input logic [31:0] rsp_local
);
    logic [31:0] local_ofs;
    assign local_ofs = rsp_local - LBASE;

    p_rsp_after_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);

    p_no_rsp_without_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);

    p_quiet_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rsp_valid || !rsp_hit) |-> (!rsp_hit && rsp_win == 2'd0 && rsp_local == 32'd0));

    p_index_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (int'(rsp_win) < NWIN));

    p_offset_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (!rsp_hit || local_ofs[GRAN-1:0] == $past(lk_addr[GRAN-1:0])));
endmodule

bind imw_decoder imw_decoder_chk #(
    .GRAN  (imw_pkg::GRAN_LOG2),
    .NWIN  (imw_pkg::NUM_WIN),
    .LBASE (LOCAL_BASE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .lk_addr   (lk_addr),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_win   (rsp_win),
    .rsp_local (rsp_local)
);

// File: tb/imw_decoder_bench.sv
`timescale 1ns/1ps
module imw_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        rsp_valid, rsp_hit;
    logic [1:0]  rsp_win;
    logic [31:0] rsp_local;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    imw_decoder u_imw_decoder (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_win(rsp_win),
        .rsp_local(rsp_local)
    );

    task automatic expect_rsp(string req, logic v, logic h, logic [1:0] w, logic [31:0] l);
        checks++;
        if (rsp_valid !== v || rsp_hit !== h || rsp_win !== w || rsp_local !== l) begin
            errors++;
            $display("FAIL %s: got v=%b h=%b w=%0d l=%h, expected v=%b h=%b w=%0d l=%h",
                     req, rsp_valid, rsp_hit, rsp_win, rsp_local, v, h, w, l);
        end
    endtask

    task automatic write_reg(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic lookup(string req, logic [31:0] a, logic h, logic [1:0] w, logic [31:0] l);
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = a;
        @(negedge clk);
        lk_valid = 1'b0;
        expect_rsp(req, 1'b1, h, w, l);
    endtask

    task automatic t_reset;
        expect_rsp("R1 reset outputs", 1'b0, 1'b0, 2'd0, 32'h0);
        lookup("R1 all windows off", 32'h0000_1234, 1'b0, 2'd0, 32'h0);
        lookup("R1 all windows off high", 32'hFFF0_0000, 1'b0, 2'd0, 32'h0);
    endtask

    task automatic t_idle;
        @(negedge clk);
        expect_rsp("R8 idle cycle", 1'b0, 1'b0, 2'd0, 32'h0);
    endtask

    task automatic t_16mb;
        write_reg(8'h50, 32'h1004_0000);
        lookup("R3 R7 inside 16MB", 32'h1012_3456, 1'b1, 2'd0, 32'h0012_3456);
        lookup("R3 top edge",       32'h10FF_FFFF, 1'b1, 2'd0, 32'h00FF_FFFF);
        lookup("R3 bottom edge",    32'h1000_0000, 1'b1, 2'd0, 32'h0);
        lookup("R3 above window",   32'h1100_0000, 1'b0, 2'd0, 32'h0);
        lookup("R3 below window",   32'h0FFF_FFFF, 1'b0, 2'd0, 32'h0);
        t_idle();
    endtask

    task automatic t_1mb;
        write_reg(8'h54, 32'h2030_0000);
        lookup("R3 1MB base",   32'h2030_0000, 1'b1, 2'd1, 32'h0);
        lookup("R3 1MB top",    32'h203F_FFFF, 1'b1, 2'd1, 32'h000F_FFFF);
        lookup("R3 1MB above",  32'h2040_0000, 1'b0, 2'd0, 32'h0);
        lookup("R3 1MB below",  32'h202F_FFFF, 1'b0, 2'd0, 32'h0);
    endtask

    task automatic t_2gb;
        write_reg(8'h58, 32'h800B_0000);
        lookup("R3 2GB top",   32'hFFFF_FFFF, 1'b1, 2'd2, 32'h7FFF_FFFF);
        lookup("R3 2GB base",  32'h8000_0000, 1'b1, 2'd2, 32'h0);
        lookup("R3 2GB below", 32'h7FFF_FFFF, 1'b0, 2'd0, 32'h0);
    endtask

    task automatic t_misaligned;
        write_reg(8'h54, 32'h2355_0000);
        lookup("R4 ignored base bits low", 32'h2200_0000, 1'b1, 2'd1, 32'h0);
        lookup("R4 ignored base bits mid", 32'h2345_6789, 1'b1, 2'd1, 32'h0145_6789);
        lookup("R4 outside",               32'h2400_0000, 1'b0, 2'd0, 32'h0);
    endtask

    task automatic t_priority;
        write_reg(8'h50, 32'h0007_0000);
        write_reg(8'h54, 32'h000A_0000);
        lookup("R6 overlap 0 and 1",    32'h0100_0000, 1'b1, 2'd0, 32'h0100_0000);
        lookup("R6 only window 1",      32'h0900_0000, 1'b1, 2'd1, 32'h0900_0000);
        write_reg(8'h58, 32'h000B_0000);
        lookup("R6 overlap 1 and 2",    32'h3000_0000, 1'b1, 2'd1, 32'h3000_0000);
        lookup("R6 only window 2",      32'h5000_0000, 1'b1, 2'd2, 32'h5000_0000);
    endtask

    task automatic t_reserved;
        write_reg(8'h50, 32'h000C_0000);
        lookup("R5 code C skips window 0", 32'h0100_0000, 1'b1, 2'd1, 32'h0100_0000);
        write_reg(8'h54, 32'h000F_0000);
        lookup("R5 code F skips window 1", 32'h0100_0000, 1'b1, 2'd2, 32'h0100_0000);
        write_reg(8'h58, 32'h000D_0000);
        lookup("R5 all reserved", 32'h0100_0000, 1'b0, 2'd0, 32'h0);
    endtask

    task automatic t_ignored;
        write_reg(8'h5C, 32'h000B_0000);
        write_reg(8'h4C, 32'h000B_0000);
        write_reg(8'h51, 32'h000B_0000);
        lookup("R2 stray offsets", 32'h0100_0000, 1'b0, 2'd0, 32'h0);
        write_reg(8'h50, 32'h3000_FFFF);
        lookup("R2 low data bits ignored", 32'h3000_0010, 1'b1, 2'd0, 32'h10);
        lookup("R2 low data bits ignored edge", 32'h3010_0000, 1'b0, 2'd0, 32'h0);
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 8'h50; cfg_wdata = 32'h4000_0000;
        lk_valid = 1'b1; lk_addr = 32'h4000_0000;
        @(negedge clk);
        cfg_we = 1'b0; lk_valid = 1'b0;
        expect_rsp("R9 lookup sees old window", 1'b1, 1'b0, 2'd0, 32'h0);
        lookup("R9 next lookup sees new window", 32'h4000_0000, 1'b1, 2'd0, 32'h0);
        lookup("R9 old window gone", 32'h3000_0010, 1'b0, 2'd0, 32'h0);
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = 32'h4000_0004;
        @(negedge clk);
        expect_rsp("R8 first of pair", 1'b1, 1'b1, 2'd0, 32'h4);
        lk_addr = 32'h7000_0000;
        @(negedge clk);
        lk_valid = 1'b0;
        expect_rsp("R8 second of pair", 1'b1, 1'b0, 2'd0, 32'h0);
        @(negedge clk);
        expect_rsp("R8 after pair", 1'b0, 1'b0, 2'd0, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_16mb();
        t_1mb();
        t_2gb();
        t_misaligned();
        t_priority();
        t_reserved();
        t_ignored();
        t_same_cycle();
        t_back_to_back();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: run did not complete, expected completion");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule